// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings an SDRAM device out of power-up and then keeps it refreshed. After reset it waits out the power-up delay. It then offers a fixed series of initialization commands to the command controller, one at a time: a precharge of all banks, a configurable number of auto-refresh commands, and a mode register load. Each command is held on the outputs until the controller reports that the command reached the pins. The block times the gap that each command requires before the next one is offered. When the mode register delay has elapsed, it raises `init_done` and stays in normal operation until the next reset.

In normal operation a free-running interval counter produces one refresh request per refresh period. Requests that have not yet been granted accumulate in a pending counter, so an interval that expires before the previous refresh was granted is not lost. When the SDRAM pins are shared with other devices, an arbiter may hold back the grant. If a request goes ungranted for too long, the block pulses a starvation output. All time intervals are given in nanoseconds and converted to clock cycles by rounding up.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is held and in the first cycle after its release, `init_cmd_valid`, `init_done`, `ref_req` and `starve` are 0 and `ref_pending` is 0.
- R2: No initialization command is offered until the power-up delay has elapsed. With the defaults (8000 ps clock, 100000 ns delay), the first command is offered exactly 12500 rising edges after reset is released.
- R3: The commands are offered in this order: one precharge-all (`init_cmd` = 1), then INIT_REFS auto-refreshes (`init_cmd` = 2), then one mode register load (`init_cmd` = 3).
- R4: A command is issued in the cycle where `init_cmd_valid` and `cmd_issued` are both high. The next command is offered ceil(t_rp/clock) cycles after a precharge is issued, and ceil(t_rfc/clock) cycles after each auto-refresh is issued. The defaults give 3 and 9 cycles.
- R5: Once offered, a command stays valid and unchanged until it is issued. No command is offered during a wait.
- R6: While the mode register load is offered, `mode_word` has burst length 1 (bits 2:0 = 0), sequential burst type (bit 3 = 0), the CAS latency in bits 6:4, and all other bits 0. The default CAS latency of 3 gives 0x030.
- R7: `init_done` rises TMRD_CYC cycles after the mode register load is issued, stays high until reset, and no initialization command is offered after it.
- R8: `ref_req` first rises ceil(t_ref/clock) cycles after `init_done` rises (1954 cycles by default) and the interval then repeats at that period. `ref_req` is never high before `init_done`.
- R9: `ref_pending` increments at each interval expiry and decrements on each cycle in which `ref_gnt` is high while `ref_req` is high. `ref_req` is high whenever `ref_pending` is nonzero.
- R10: When STARVE_EN is 1 and `ref_req` stays high with `ref_gnt` low, `starve` pulses for one cycle in the STARVE_CYC-th such cycle, and again every STARVE_CYC cycles while the condition lasts.
- R11: `ref_gnt` while `ref_req` is low has no effect: `ref_pending` stays 0 and the refresh schedule is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_issued | input | 1 | Controller drove the offered init command this cycle |
| ref_gnt | input | 1 | Controller granted one refresh this cycle |
| init_cmd_valid | output | 1 | An initialization command is offered |
| init_cmd | output | 2 | Offered command: 1 precharge-all, 2 auto-refresh, 3 mode load |
| mode_word | output | ROW_W | Address value for the mode register load |
| init_done | output | 1 | Initialization complete |
| ref_req | output | 1 | At least one refresh is owed |
| ref_pending | output | PEND_W | Number of refreshes owed |
| starve | output | 1 | One-cycle pulse when a refresh has waited too long |

## Verification
A wrong wait counter or phase shows as a command offered one or more cycles early or late. That error appears at the very next `init_cmd_valid` edge, so the bench checks the exact cycle in which each command is first offered, and also checks the cycle just before it. A wrong refresh-count register changes the number of auto-refresh commands before the mode load, and this is visible before `init_done`. Errors in the interval, pending or starvation counters shift the rising edge of `ref_req`, leave `ref_pending` at the wrong value after grants, or move `starve` by a cycle. Each of these errors appears within one refresh period.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_NOP           = 2'd0,
    SEQ_PRECHARGE_ALL = 2'd1,
    SEQ_AUTO_REFRESH  = 2'd2,
    SEQ_LOAD_MODE     = 2'd3
  } seq_cmd_e;

  // Convert nanoseconds to clock cycles, rounding up, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ps);
    int c;
    c = (t_ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  // Mode register value: burst length 1, sequential, given CAS latency.
  function automatic logic [11:0] mode_bits(input int cas);
    logic [11:0] m;
    m = '0;
    m[2:0] = 3'b000;
    m[3]   = 1'b0;
    m[6:4] = 3'(cas);
    return m;
  endfunction

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_seq_pkg::*;
#(
  parameter int PWR_CYC   = 12500,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 9,
  parameter int TMRD_CYC  = 2,
  parameter int INIT_REFS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_issued,
  output logic     cmd_valid,
  output seq_cmd_e cmd,
  output logic     done
);
  localparam int WC_W = $clog2(PWR_CYC + 1);
  localparam int RC_W = $clog2(INIT_REFS + 1);

  typedef enum logic [1:0] {PH_PRE, PH_REF, PH_LMR, PH_FIN} phase_e;

  phase_e           phase;
  logic [WC_W-1:0]  wcnt;
  logic [RC_W-1:0]  refs_left;
  logic             waiting;
  logic             fire;

  assign waiting   = (wcnt != '0);
  assign cmd_valid = !waiting && (phase != PH_FIN);
  assign fire      = cmd_valid && cmd_issued;
  assign done      = !waiting && (phase == PH_FIN);

  always_comb begin
    unique case (phase)
      PH_PRE:  cmd = SEQ_PRECHARGE_ALL;
      PH_REF:  cmd = SEQ_AUTO_REFRESH;
      PH_LMR:  cmd = SEQ_LOAD_MODE;
      default: cmd = SEQ_NOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_PRE;
      wcnt      <= WC_W'(PWR_CYC);
      refs_left <= RC_W'(INIT_REFS);
    end else if (waiting) begin
      wcnt <= wcnt - 1'b1;
    end else if (fire) begin
      unique case (phase)
        PH_PRE: begin
          phase <= PH_REF;
          wcnt  <= WC_W'(TRP_CYC - 1);
        end
        PH_REF: begin
          if (refs_left == RC_W'(1)) phase <= PH_LMR;
          refs_left <= refs_left - 1'b1;
          wcnt      <= WC_W'(TRFC_CYC - 1);
        end
        PH_LMR: begin
          phase <= PH_FIN;
          wcnt  <= WC_W'(TMRD_CYC - 1);
        end
        default: ;
      endcase
    end
  end

  // R5: an offered command is held unchanged until taken
  a_r5_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_issued |=> cmd_valid && $stable(cmd));

  // R7: once complete, stays complete
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R3: no init command after completion
  a_r3_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid);

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_CYC = 1954,
  parameter int PEND_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              gnt,
  output logic              req,
  output logic [PEND_W-1:0] pending
);
  localparam int IC_W = $clog2(REF_CYC + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [IC_W-1:0] icnt;
  logic            tick;
  logic            take;
  logic            add;

  assign tick = run && (icnt == IC_W'(REF_CYC - 1));
  assign req  = (pending != '0);
  assign take = gnt && req;
  assign add  = tick && (pending != PEND_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
    end else if (run) begin
      icnt <= tick ? '0 : icnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
    end else if (add && !take) begin
      pending <= pending + 1'b1;
    end else if (take && !add) begin
      pending <= pending - 1'b1;
    end
  end

  // R9: an expiry without a grant is never lost (below saturation)
  a_r9_no_lost_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !take && (pending != PEND_MAX) |=> pending == $past(pending) + 1'b1);

  // R8: no request before initialization completes
  a_r8_no_early_req: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !req);

endmodule

// File: rtl/sdram_starve_mon.sv
module sdram_starve_mon #(
  parameter int STARVE_CYC = 512,
  parameter bit STARVE_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gnt,
  output logic starve
);
  generate
    if (STARVE_EN) begin : g_mon
      localparam int SC_W = $clog2(STARVE_CYC + 1);
      logic [SC_W-1:0] scnt;
      logic            held;
      logic            hit;

      assign held   = req && !gnt;
      assign hit    = held && (scnt == SC_W'(STARVE_CYC - 1));
      assign starve = hit;

      always_ff @(posedge clk) begin
        if (!rst_n || !held || hit) scnt <= '0;
        else                        scnt <= scnt + 1'b1;
      end
    end else begin : g_off
      assign starve = 1'b0;
    end
  endgenerate

  // R10: a starvation pulse only while a request is withheld
  a_r10_starve_cause: assert property (@(posedge clk) disable iff (!rst_n)
    starve |-> req && !gnt);

  // R10: the pulse lasts one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> !starve);

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdram_seq_pkg::*;
#(
  parameter int CLK_PS     = 8000,
  parameter int PWRUP_NS   = 100000,
  parameter int TRP_NS     = 20,
  parameter int TRFC_NS    = 70,
  parameter int TREF_NS    = 15625,
  parameter int TMRD_CYC   = 2,
  parameter int INIT_REFS  = 2,
  parameter int CAS_LAT    = 3,
  parameter int ROW_W      = 12,
  parameter int PEND_W     = 4,
  parameter int STARVE_CYC = 512,
  parameter bit STARVE_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_issued,
  input  logic             ref_gnt,
  output logic             init_cmd_valid,
  output logic [1:0]       init_cmd,
  output logic [ROW_W-1:0] mode_word,
  output logic             init_done,
  output logic             ref_req,
  output logic [PEND_W-1:0] ref_pending,
  output logic             starve
);
  localparam int PWR_CYC  = ns_to_cycles(PWRUP_NS, CLK_PS);
  localparam int TRP_CYC  = ns_to_cycles(TRP_NS, CLK_PS);
  localparam int TRFC_CYC = ns_to_cycles(TRFC_NS, CLK_PS);
  localparam int REF_CYC  = ns_to_cycles(TREF_NS, CLK_PS);

  seq_cmd_e cmd_e;

  sdram_init_fsm #(
    .PWR_CYC(PWR_CYC), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .TMRD_CYC(TMRD_CYC), .INIT_REFS(INIT_REFS)
  ) u_init (
    .clk(clk), .rst_n(rst_n), .cmd_issued(cmd_issued),
    .cmd_valid(init_cmd_valid), .cmd(cmd_e), .done(init_done)
  );

  assign init_cmd  = cmd_e;
  assign mode_word = ROW_W'(mode_bits(CAS_LAT));

  sdram_ref_timer #(.REF_CYC(REF_CYC), .PEND_W(PEND_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(init_done), .gnt(ref_gnt),
    .req(ref_req), .pending(ref_pending)
  );

  sdram_starve_mon #(.STARVE_CYC(STARVE_CYC), .STARVE_EN(STARVE_EN)) u_starve (
    .clk(clk), .rst_n(rst_n), .req(ref_req), .gnt(ref_gnt), .starve(starve)
  );

  // R9: a request is shown whenever refreshes are owed
  a_r9_req_matches_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pending != '0) |-> ref_req);

endmodule

// File: tb/test_sdram_init_refresh.sv
`timescale 1ns/1ps
module test_sdram_init_refresh;
  localparam int CLK_PS  = 8000;
  localparam int N_REFS  = 2;
  localparam int MRD     = 2;
  localparam int S_LIM   = 512;

  // cycles computed independently: integer part plus one if any remainder
  function automatic int cyc_of(input int ns);
    int ps;
    ps = ns * 1000;
    return ps / CLK_PS + ((ps % CLK_PS) != 0 ? 1 : 0);
  endfunction

  localparam int PWR = 12500;
  int trp, trfc, tref;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_issued = 1'b0;
  logic ref_gnt = 1'b0;
  logic init_cmd_valid, init_done, ref_req, starve;
  logic [1:0] init_cmd;
  logic [11:0] mode_word;
  logic [3:0] ref_pending;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sdram_init_refresh i_sdram_init_refresh (
    .clk(clk), .rst_n(rst_n), .cmd_issued(cmd_issued), .ref_gnt(ref_gnt),
    .init_cmd_valid(init_cmd_valid), .init_cmd(init_cmd), .mode_word(mode_word),
    .init_done(init_done), .ref_req(ref_req), .ref_pending(ref_pending),
    .starve(starve)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", rq, what, cyc, act, exp);
    end
  endtask

  task automatic at(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Offer/issue one init command; returns the cycle of issue.
  task automatic do_issue(input int code, input int exp_cyc, input int stall,
                          output int icyc);
    at(exp_cyc - 1);
    chk(init_cmd_valid == 1'b0, "R4", "not offered early", init_cmd_valid, 0);
    at(exp_cyc);
    chk(init_cmd_valid == 1'b1, "R4", "offered on time", init_cmd_valid, 1);
    chk(init_cmd == 2'(code), "R3", "command code", init_cmd, code);
    if (code == 3)
      chk(mode_word == 12'h030, "R6", "mode word", mode_word, 12'h030);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(init_cmd_valid == 1'b1 && init_cmd == 2'(code), "R5",
          "held while not issued", init_cmd, code);
    end
    cmd_issued = 1'b1;
    icyc = cyc;
    @(negedge clk);
    cmd_issued = 1'b0;
    chk(init_cmd_valid == 1'b0, "R5", "no offer during wait", init_cmd_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(init_cmd_valid == 0 && init_done == 0 && ref_req == 0 && starve == 0 &&
        ref_pending == 0, "R1", "outputs in reset", init_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(init_cmd_valid == 0 && init_done == 0 && ref_req == 0 && ref_pending == 0,
        "R1", "outputs after release", init_cmd_valid, 0);
  endtask

  task automatic t_init(output int done_cyc);
    int ic;
    do_issue(1, PWR, 0, ic);                      // R2 power-up wait, R3 precharge first
    chk(ic == PWR, "R2", "precharge issue cycle", ic, PWR);
    for (int r = 0; r < N_REFS; r++)
      do_issue(2, ic + (r == 0 ? trp : trfc), (r == 0 ? 2 : 0), ic);
    do_issue(3, ic + trfc, 1, ic);
    done_cyc = ic + MRD;
    at(done_cyc - 1);
    chk(init_done == 1'b0, "R7", "done not early", init_done, 0);
    at(done_cyc);
    chk(init_done == 1'b1, "R7", "done on time", init_done, 1);
    at(done_cyc + 5);
    chk(init_done == 1'b1 && init_cmd_valid == 1'b0, "R7", "done stays, no commands",
        init_cmd_valid, 0);
  endtask

  task automatic t_period(input int d, output int nxt);
    int first;
    first = d + tref;
    at(first - 1);
    chk(ref_req == 1'b0, "R8", "no request before first period", ref_req, 0);
    at(first);
    chk(ref_req == 1'b1 && ref_pending == 1, "R8", "first request", ref_pending, 1);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(ref_req == 1'b0 && ref_pending == 0, "R9", "grant clears request", ref_pending, 0);
    nxt = first + tref;
    at(nxt - 1);
    chk(ref_req == 1'b0, "R8", "quiet before second period", ref_req, 0);
    at(nxt);
    chk(ref_req == 1'b1, "R8", "second request on period", ref_req, 1);
  endtask

  task automatic t_starve(input int p);
    at(p + S_LIM - 2);
    chk(starve == 1'b0, "R10", "no early starve", starve, 0);
    at(p + S_LIM - 1);
    chk(starve == 1'b1, "R10", "starve pulse", starve, 1);
    at(p + S_LIM);
    chk(starve == 1'b0, "R10", "single-cycle pulse", starve, 0);
    at(p + 2 * S_LIM - 1);
    chk(starve == 1'b1, "R10", "repeat pulse", starve, 1);
  endtask

  task automatic t_pending(input int p, output int q);
    q = p + tref;
    at(q - 1);
    chk(ref_pending == 1, "R9", "one owed before expiry", ref_pending, 1);
    at(q);
    chk(ref_pending == 2, "R9", "second expiry counted", ref_pending, 2);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(ref_pending == 1 && ref_req == 1'b1, "R9", "one grant, one left", ref_pending, 1);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(ref_pending == 0 && ref_req == 1'b0, "R9", "both granted", ref_pending, 0);
  endtask

  task automatic t_idle_grant(input int q);
    ref_gnt = 1'b1;
    repeat (3) @(negedge clk);
    ref_gnt = 1'b0;
    chk(ref_pending == 0 && ref_req == 1'b0, "R11", "grant without request ignored",
        ref_pending, 0);
    at(q + tref - 1);
    chk(ref_req == 1'b0, "R11", "schedule unchanged before expiry", ref_req, 0);
    at(q + tref);
    chk(ref_req == 1'b1 && ref_pending == 1, "R11", "schedule unchanged at expiry",
        ref_pending, 1);
  endtask

  initial begin
    int d, p, q;
    trp  = cyc_of(20);
    trfc = cyc_of(70);
    tref = cyc_of(15625);
    chk(PWR == cyc_of(100000), "R2", "power-up cycle count", cyc_of(100000), PWR);
    repeat (3) @(negedge clk);
    t_reset();
    t_init(d);
    t_period(d, p);
    t_starve(p);
    t_pending(p, q);
    t_idle_grant(q);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule